// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with APB Register Access

This block is a down-counting watchdog that hangs off an APB slave port and occupies a 4 KB register window. A clock-enable input paces the counter, which moves down by one on each enabled cycle. When the counter runs out the first time, the block raises a raw interrupt flag and reloads from the reload register. Software is expected to service the interrupt by writing the clear register. If the counter runs out again while the flag is still pending, the block raises a reset flag and the counter freezes. Each flag reaches its output pin only while its enable bit in the control register is set.

Stray writes can be blocked. Writing a key value to the lock register opens the block, and any other value closes it. Integration-test registers let the two outputs be driven directly from software. A parameter selects a reduced variant. In that variant the test registers are absent, and the control register stops accepting writes once interrupts have been enabled.

Top module: `apb_wdog`

## Requirements
- R1: After a synchronous reset, the reload register (0x000) and the count (0x004) read 0xFFFFFFFF. Control (0x008), lock (0xC00) and the test registers read 0. Both outputs are low and counting is active.
- R2: Each cycle with `cnt_en` high and the counter running, a nonzero count decreases by one. With `cnt_en` low, the count holds.
- R3: A write to 0x000 sets the reload value and the count to the written value and restarts counting, including after a stop.
- R4: An enabled cycle with count zero and the raw flag clear is the first expiry. It sets the raw flag (bit 0 of 0x010) and reloads the count from the reload value.
- R5: An enabled cycle with count zero and the raw flag set is the second expiry. It sets the reset flag, and the count then freezes. The reset flag stays set until system reset, and writes to 0x00C do not clear it.
- R6: Any write to 0x00C clears the raw flag and reloads the count from the reload value.
- R7: Control bit 0 gates the raw flag onto `irq_o` and bit 1 gates the reset flag onto `rst_req_o`. Control bits above bit 1 are dropped on write. Offset 0x014 bit 0 reads the gated interrupt.
- R8: Writing 0x1ACCE551 to 0xC00 unlocks the block, and any other value locks it. While locked, writes to every other offset have no effect. 0xC00 reads 1 when locked and 0 when unlocked.
- R9: In the full variant, while bit 0 of 0xF00 is set, `rst_req_o` follows bit 0 of 0xF04 and `irq_o` follows bit 1 of 0xF04. 0xF00 reads back its bit 0.
- R10: In the reduced variant, 0xF00 and 0xF04 read 0 and writes to them have no effect on the outputs. Once control bit 0 is 1, writes to 0x008 are ignored until reset. Before that, writes to 0x008 are accepted.
- R11: Offsets 0xFD0 through 0xFFC return one ID byte per word, in this order: 0x04, 0x00, 0x00, 0x00, 0x57, 0xD0, 0x0A, 0x00, 0x0D, 0xF0, 0x05, 0xB1. In the reduced variant, the word at 0xFD0 reads 0x00 and the word at 0xFE0 reads 0x58. Writes to these offsets have no effect.
- R12: Reads of write-only offsets (0x00C, 0xF04) and of unmapped offsets return 0. Writes to read-only or unmapped offsets change nothing. `pready` is always 1 and `pslverr` is always 0.
- R13: A write to 0x00C in the same cycle as an expiry takes priority. The raw flag ends clear, the count reloads, and no reset flag is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count enable, one decrement per high cycle |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 12 | APB byte address within the window |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, tied high |
| pslverr | output | 1 | APB error, tied low |
| irq_o | output | 1 | Watchdog interrupt |
| rst_req_o | output | 1 | Watchdog reset request |

## Verification
The bench builds the double-expiry sequence with exact tick counts. It checks that the first expiry reloads and only flags, and that a design which reset on the first expiry, or kept counting after the second, would show a wrong count or a stray `rst_req_o`. It writes a clear in the same cycle as an expiry; a design that let the expiry win would raise the reset flag there. It writes to the reload, control and clear registers while locked, and a lock that leaked would change readback values. It checks that the reset flag survives clear writes. A second instance in the reduced variant shows whether the control register freezes and whether the test registers are ignored.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int AW = 12;
    localparam int DW = 32;

    localparam logic [AW-1:0] OFS_LOAD  = 12'h000;
    localparam logic [AW-1:0] OFS_VALUE = 12'h004;
    localparam logic [AW-1:0] OFS_CTRL  = 12'h008;
    localparam logic [AW-1:0] OFS_ICLR  = 12'h00C;
    localparam logic [AW-1:0] OFS_RAW   = 12'h010;
    localparam logic [AW-1:0] OFS_MSK   = 12'h014;
    localparam logic [AW-1:0] OFS_LOCK  = 12'hC00;
    localparam logic [AW-1:0] OFS_TCTL  = 12'hF00;
    localparam logic [AW-1:0] OFS_TOUT  = 12'hF04;
    localparam logic [AW-1:0] OFS_ID_LO = 12'hFD0;

    localparam logic [DW-1:0] UNLOCK_KEY = 32'h1ACCE551;

    typedef enum logic [3:0] {
        RG_NONE, RG_LOAD, RG_VALUE, RG_CTRL, RG_ICLR, RG_RAW,
        RG_MSK, RG_LOCK, RG_TCTL, RG_TOUT, RG_ID
    } reg_sel_e;

    // bit 0 = interrupt enable, bit 1 = reset enable
    typedef struct packed {
        logic rst_en;
        logic irq_en;
    } ctrl_t;

    typedef struct packed {
        logic          load;
        logic          clear;
        logic [DW-1:0] data;
    } cnt_cmd_t;

    function automatic reg_sel_e decode(input logic [AW-1:0] a);
        reg_sel_e s;
        case (a[AW-1:2])
            OFS_LOAD[AW-1:2]:  s = RG_LOAD;
            OFS_VALUE[AW-1:2]: s = RG_VALUE;
            OFS_CTRL[AW-1:2]:  s = RG_CTRL;
            OFS_ICLR[AW-1:2]:  s = RG_ICLR;
            OFS_RAW[AW-1:2]:   s = RG_RAW;
            OFS_MSK[AW-1:2]:   s = RG_MSK;
            OFS_LOCK[AW-1:2]:  s = RG_LOCK;
            OFS_TCTL[AW-1:2]:  s = RG_TCTL;
            OFS_TOUT[AW-1:2]:  s = RG_TOUT;
            default:           s = (a[AW-1:2] >= OFS_ID_LO[AW-1:2]) ? RG_ID : RG_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [7:0] id_byte(input logic [3:0] idx, input bit reduced);
        logic [7:0] b;
        case (idx)
            4'd0:    b = reduced ? 8'h00 : 8'h04;
            4'd4:    b = reduced ? 8'h58 : 8'h57;
            4'd5:    b = 8'hD0;
            4'd6:    b = 8'h0A;
            4'd8:    b = 8'h0D;
            4'd9:    b = 8'hF0;
            4'd10:   b = 8'h05;
            4'd11:   b = 8'hB1;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  cnt_cmd_t         cmd,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] load_val,
    output logic             int_raw,
    output logic             rst_flag
);

    logic running;
    logic at_zero;

    assign at_zero = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            load_val <= '1;
            cnt      <= '1;
            running  <= 1'b1;
            int_raw  <= 1'b0;
            rst_flag <= 1'b0;
        end else if (cmd.load) begin
            load_val <= cmd.data[CNT_W-1:0];
            cnt      <= cmd.data[CNT_W-1:0];
            running  <= 1'b1;
        end else if (cmd.clear) begin
            int_raw <= 1'b0;
            cnt     <= load_val;
        end else if (running && cnt_en) begin
            if (!at_zero) begin
                cnt <= cnt - 1'b1;
            end else if (!int_raw) begin
                int_raw <= 1'b1;
                cnt     <= load_val;
            end else begin
                rst_flag <= 1'b1;
                running  <= 1'b0;
            end
        end
    end

    AST_FIRST_EXPIRY: assert property (@(posedge clk) disable iff (rst)
        (running && cnt_en && at_zero && !int_raw && !cmd.load && !cmd.clear)
        |=> (int_raw && !rst_flag && cnt == $past(load_val)));  // R4

    AST_SECOND_EXPIRY: assert property (@(posedge clk) disable iff (rst)
        (running && cnt_en && at_zero && int_raw && !cmd.load && !cmd.clear)
        |=> (rst_flag && !running));  // R5

    AST_RST_STICKY: assert property (@(posedge clk) disable iff (rst)
        rst_flag |=> rst_flag);  // R5

    AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!running && !cmd.load && !cmd.clear) |=> $stable(cnt));  // R5

    AST_NO_COUNT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && !cmd.load && !cmd.clear) |=> $stable(cnt));  // R2

    AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (rst)
        cmd.load |=> (running && cnt == $past(cmd.data[CNT_W-1:0])));  // R3

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        (cmd.clear && !cmd.load) |=> (!int_raw && $stable(rst_flag)));  // R13

endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter bit REDUCED = 1'b0,
    parameter int CNT_W   = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             psel,
    input  logic             penable,
    input  logic             pwrite,
    input  logic [AW-1:0]    paddr,
    input  logic [DW-1:0]    pwdata,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] load_val,
    input  logic             int_raw,
    output cnt_cmd_t         cmd,
    output ctrl_t            ctrl,
    output logic             test_en,
    output logic [1:0]       test_out,
    output logic [DW-1:0]    prdata
);

    localparam logic [AW-3:0] ID_BASE_W = OFS_ID_LO[AW-1:2];

    reg_sel_e      sel;
    logic          wr;
    logic          wr_ok;
    logic          locked;
    logic          ctrl_frozen;
    logic [AW-3:0] id_off;

    assign sel         = decode(paddr);
    assign wr          = psel && penable && pwrite;
    assign wr_ok       = wr && !locked;
    assign ctrl_frozen = REDUCED && ctrl.irq_en;
    assign id_off      = paddr[AW-1:2] - ID_BASE_W;

    assign cmd.load  = wr_ok && (sel == RG_LOAD);
    assign cmd.clear = wr_ok && (sel == RG_ICLR);
    assign cmd.data  = pwdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            locked <= 1'b0;
            ctrl   <= '0;
        end else begin
            if (wr && sel == RG_LOCK) begin
                locked <= (pwdata != UNLOCK_KEY);
            end
            if (wr_ok && sel == RG_CTRL && !ctrl_frozen) begin
                ctrl <= ctrl_t'(pwdata[1:0]);
            end
        end
    end

    generate
        if (REDUCED) begin : g_no_test
            assign test_en  = 1'b0;
            assign test_out = 2'b00;
        end else begin : g_test
            logic       tctl_q;
            logic [1:0] tout_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    tctl_q <= 1'b0;
                    tout_q <= 2'b00;
                end else begin
                    if (wr_ok && sel == RG_TCTL) tctl_q <= pwdata[0];
                    if (wr_ok && sel == RG_TOUT) tout_q <= pwdata[1:0];
                end
            end
            assign test_en  = tctl_q;
            assign test_out = tout_q;
        end
    endgenerate

    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            case (sel)
                RG_LOAD:  prdata = DW'(load_val);
                RG_VALUE: prdata = DW'(cnt);
                RG_CTRL:  prdata = DW'(ctrl);
                RG_RAW:   prdata = DW'(int_raw);
                RG_MSK:   prdata = DW'(int_raw && ctrl.irq_en);
                RG_LOCK:  prdata = DW'(locked);
                RG_TCTL:  prdata = DW'(test_en);
                RG_ID:    prdata = DW'(id_byte(id_off[3:0], REDUCED));
                default:  prdata = '0;
            endcase
        end
    end

    AST_LOCK_HOLDS_CTRL: assert property (@(posedge clk) disable iff (rst)
        (locked && wr && sel == RG_CTRL) |=> $stable(ctrl));  // R8

    AST_LOCK_READ: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == RG_LOCK && pwdata != UNLOCK_KEY) |=> locked);  // R8

    generate
        if (REDUCED) begin : g_sticky_chk
            AST_STICKY_CTRL: assert property (@(posedge clk) disable iff (rst)
                ctrl.irq_en |=> $stable(ctrl));  // R10
        end
    endgenerate

endmodule

// File: rtl/wdog_outmux.sv
module wdog_outmux
    import wdog_pkg::*;
(
    input  ctrl_t      ctrl,
    input  logic       int_raw,
    input  logic       rst_flag,
    input  logic       test_en,
    input  logic [1:0] test_out,
    output logic       irq,
    output logic       rst_req
);

    always_comb begin
        if (test_en) begin
            rst_req = test_out[0];
            irq     = test_out[1];
        end else begin
            rst_req = rst_flag && ctrl.rst_en;
            irq     = int_raw && ctrl.irq_en;
        end
    end

endmodule

// File: rtl/apb_wdog.sv
module apb_wdog
    import wdog_pkg::*;
#(
    parameter bit REDUCED = 1'b0,
    parameter int CNT_W   = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cnt_en,
    input  logic          psel,
    input  logic          penable,
    input  logic          pwrite,
    input  logic [11:0]   paddr,
    input  logic [31:0]   pwdata,
    output logic [31:0]   prdata,
    output logic          pready,
    output logic          pslverr,
    output logic          irq_o,
    output logic          rst_req_o
);

    cnt_cmd_t         cmd;
    ctrl_t            ctrl;
    logic             test_en;
    logic [1:0]       test_out;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] load_val;
    logic             int_raw;
    logic             rst_flag;

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    wdog_regs #(.REDUCED(REDUCED), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst),
        .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata),
        .cnt(cnt), .load_val(load_val), .int_raw(int_raw),
        .cmd(cmd), .ctrl(ctrl), .test_en(test_en), .test_out(test_out),
        .prdata(prdata)
    );

    wdog_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .cmd(cmd),
        .cnt(cnt), .load_val(load_val), .int_raw(int_raw), .rst_flag(rst_flag)
    );

    wdog_outmux u_out (
        .ctrl(ctrl), .int_raw(int_raw), .rst_flag(rst_flag),
        .test_en(test_en), .test_out(test_out),
        .irq(irq_o), .rst_req(rst_req_o)
    );

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        (!test_en && !ctrl.irq_en) |-> !irq_o);  // R7

    AST_RSTREQ_GATED: assert property (@(posedge clk) disable iff (rst)
        (!test_en && !ctrl.rst_en) |-> !rst_req_o);  // R7

    AST_TEST_DRIVE: assert property (@(posedge clk) disable iff (rst)
        test_en |-> (rst_req_o == test_out[0] && irq_o == test_out[1]));  // R9

    AST_BUS_OK: assert property (@(posedge clk) disable iff (rst)
        pready && !pslverr);  // R12

endmodule

// File: tb/apb_wdog_tb.sv
module apb_wdog_tb_top;

    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_TK = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [11:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 46;
    localparam vec_t VEC [NV] = '{
        '{OP_RD, 12'h000, 32'h0, 32'hFFFFFFFF, 4'd1},   // R1
        '{OP_RD, 12'h004, 32'h0, 32'hFFFFFFFF, 4'd1},   // R1
        '{OP_RD, 12'h008, 32'h0, 32'h0, 4'd1},          // R1
        '{OP_RD, 12'hC00, 32'h0, 32'h0, 4'd1},          // R1
        '{OP_RD, 12'hF00, 32'h0, 32'h0, 4'd1},          // R1
        '{OP_WR, 12'h000, 32'd10, 32'h0, 4'd3},
        '{OP_RD, 12'h004, 32'h0, 32'd10, 4'd3},         // R3
        '{OP_RD, 12'h000, 32'h0, 32'd10, 4'd3},         // R3
        '{OP_TK, 12'h000, 32'd4, 32'h0, 4'd2},
        '{OP_RD, 12'h004, 32'h0, 32'd6, 4'd2},          // R2
        '{OP_WR, 12'h008, 32'hFFFFFFFF, 32'h0, 4'd7},
        '{OP_RD, 12'h008, 32'h0, 32'd3, 4'd7},          // R7
        '{OP_RD, 12'h014, 32'h0, 32'd0, 4'd7},          // R7
        '{OP_TK, 12'h000, 32'd7, 32'h0, 4'd4},
        '{OP_RD, 12'h010, 32'h0, 32'd1, 4'd4},          // R4
        '{OP_RD, 12'h004, 32'h0, 32'd10, 4'd4},         // R4
        '{OP_RD, 12'h014, 32'h0, 32'd1, 4'd7},          // R7
        '{OP_WR, 12'h00C, 32'h0, 32'h0, 4'd6},
        '{OP_RD, 12'h010, 32'h0, 32'd0, 4'd6},          // R6
        '{OP_RD, 12'h014, 32'h0, 32'd0, 4'd6},          // R6
        '{OP_WR, 12'hC00, 32'h12345678, 32'h0, 4'd8},
        '{OP_RD, 12'hC00, 32'h0, 32'd1, 4'd8},          // R8
        '{OP_WR, 12'h000, 32'd5, 32'h0, 4'd8},
        '{OP_RD, 12'h000, 32'h0, 32'd10, 4'd8},         // R8
        '{OP_WR, 12'h008, 32'h0, 32'h0, 4'd8},
        '{OP_RD, 12'h008, 32'h0, 32'd3, 4'd8},          // R8
        '{OP_TK, 12'h000, 32'd3, 32'h0, 4'd2},
        '{OP_WR, 12'h00C, 32'h0, 32'h0, 4'd8},
        '{OP_RD, 12'h004, 32'h0, 32'd7, 4'd8},          // R8 locked clear ignored
        '{OP_WR, 12'hC00, 32'h1ACCE551, 32'h0, 4'd8},
        '{OP_RD, 12'hC00, 32'h0, 32'd0, 4'd8},          // R8
        '{OP_RD, 12'h00C, 32'h0, 32'd0, 4'd12},         // R12
        '{OP_RD, 12'h800, 32'h0, 32'd0, 4'd12},         // R12
        '{OP_WR, 12'h004, 32'h55, 32'h0, 4'd12},
        '{OP_RD, 12'h004, 32'h0, 32'd7, 4'd12},         // R12
        '{OP_WR, 12'h800, 32'h1, 32'h0, 4'd12},
        '{OP_RD, 12'h010, 32'h0, 32'd0, 4'd12},         // R12
        '{OP_RD, 12'hFD0, 32'h0, 32'h04, 4'd11},        // R11
        '{OP_RD, 12'hFE0, 32'h0, 32'h57, 4'd11},        // R11
        '{OP_WR, 12'hFE0, 32'hFF, 32'h0, 4'd11},
        '{OP_RD, 12'hFE0, 32'h0, 32'h57, 4'd11},        // R11
        '{OP_RD, 12'hFFC, 32'h0, 32'hB1, 4'd11},        // R11
        '{OP_TK, 12'h000, 32'd8, 32'h0, 4'd4},
        '{OP_RD, 12'h010, 32'h0, 32'd1, 4'd4},          // R4
        '{OP_TK, 12'h000, 32'd11, 32'h0, 4'd5},
        '{OP_RD, 12'h004, 32'h0, 32'd0, 4'd5}           // R5
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_en = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic        tsel = 1'b0;

    logic [31:0] prdata_d, prdata_v;
    logic        pready_d, pslverr_d, irq_d, rrq_d;
    logic        pready_v, pslverr_v, irq_v, rrq_v;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    apb_wdog #(.REDUCED(1'b0)) dut_i (
        .clk(clk), .rst(rst), .cnt_en(cnt_en),
        .psel(psel && !tsel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata_d),
        .pready(pready_d), .pslverr(pslverr_d), .irq_o(irq_d), .rst_req_o(rrq_d)
    );

    apb_wdog #(.REDUCED(1'b1)) dut_v (
        .clk(clk), .rst(rst), .cnt_en(cnt_en),
        .psel(psel && tsel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata_v),
        .pready(pready_v), .pslverr(pslverr_v), .irq_o(irq_v), .rst_req_o(rrq_v)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic apb_wr(input logic [11:0] a, input logic [31:0] d, input bit en = 1'b0);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1; cnt_en = en;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0; cnt_en = 1'b0;
    endtask

    task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #1 d = tsel ? prdata_v : prdata_d;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic tick(input int n);
        cnt_en = 1'b1;
        repeat (n) @(negedge clk);
        cnt_en = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: run hung actual=%0d expected<=50000 cycles", cyc);
            finish_run();
        end
    end

    initial begin
        logic [31:0] r;
        @(negedge clk);
        do_reset();

        // R1: ports after reset
        check("R1 irq", irq_d, 0);
        check("R1 rst_req", rrq_d, 0);
        check("R12 pready", pready_d, 1);
        check("R12 pslverr", pslverr_d, 0);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                OP_WR: apb_wr(VEC[i].addr, VEC[i].data);
                OP_TK: tick(int'(VEC[i].data));
                default: begin
                    apb_rd(VEC[i].addr, r);
                    check($sformatf("R%0d vec%0d", VEC[i].req, i), r, VEC[i].exp);
                end
            endcase
        end

        // R5: frozen after second expiry, reset request visible
        tick(5);
        apb_rd(12'h004, r); check("R5 frozen", r, 0);
        check("R5 rst_req", rrq_d, 1);
        check("R7 irq", irq_d, 1);
        apb_wr(12'h008, 32'h1);
        check("R7 rst gated", rrq_d, 0);
        check("R7 irq on", irq_d, 1);
        apb_wr(12'h008, 32'h2);
        check("R7 irq gated", irq_d, 0);
        check("R7 rst on", rrq_d, 1);
        apb_wr(12'h00C, 32'h0);
        check("R5 held after clear", rrq_d, 1);

        // R9: test override
        apb_wr(12'h008, 32'h0);
        apb_wr(12'hF00, 32'h1);
        apb_wr(12'hF04, 32'h1);
        check("R9 rst from test", rrq_d, 1);
        check("R9 irq from test", irq_d, 0);
        apb_wr(12'hF04, 32'h2);
        check("R9 irq from test2", irq_d, 1);
        check("R9 rst from test2", rrq_d, 0);
        apb_rd(12'hF00, r); check("R9 tctl read", r, 1);
        apb_rd(12'hF04, r); check("R12 tout wo", r, 0);
        apb_wr(12'hF00, 32'h0);
        check("R9 back to normal", irq_d, 0);

        // R3: load restarts a stopped counter
        apb_wr(12'h000, 32'd3);
        tick(2);
        apb_rd(12'h004, r); check("R3 restart", r, 1);

        // R13: clear in the same cycle as a second expiry
        do_reset();
        check("R1 rst_req after reset", rrq_d, 0);
        apb_wr(12'h000, 32'd0);
        tick(1);
        apb_rd(12'h010, r); check("R4 zero load expiry", r, 1);
        apb_wr(12'h00C, 32'h0, 1'b1);
        apb_rd(12'h010, r); check("R13 clear wins", r, 0);
        apb_wr(12'h008, 32'h3);
        check("R13 no reset flag", rrq_d, 0);

        // R10/R11: reduced variant
        tsel = 1'b1;
        apb_wr(12'hF00, 32'h1);
        apb_wr(12'hF04, 32'h3);
        apb_rd(12'hF00, r); check("R10 no tctl", r, 0);
        check("R10 outputs untouched", irq_v, 0);
        check("R10 rst untouched", rrq_v, 0);
        apb_wr(12'h008, 32'h2);
        apb_rd(12'h008, r); check("R10 ctrl writable", r, 2);
        apb_wr(12'h008, 32'h1);
        apb_wr(12'h008, 32'h0);
        apb_rd(12'h008, r); check("R10 ctrl frozen", r, 1);
        apb_rd(12'hFD0, r); check("R11 variant id0", r, 32'h00);
        apb_rd(12'hFE0, r); check("R11 variant id4", r, 32'h58);
        tsel = 1'b0;

        finish_run();
    end

endmodule